// File: doc/BRIEF.md
# Multi-Operand Carry-Save Summation Tree

This combinational block adds a fixed set of N operands into one W-bit result, wrapping modulo 2^W. Each operand has an elaboration-time meaningful width, a signed/unsigned flag and an add/subtract flag. After each operand is brought to W bits, the block reduces the whole set with layers of 3:2 full-adder compressors until two vectors remain. One carry-propagate adder then combines those two vectors. The tree therefore has only a logarithmic number of full-adder levels in front of a single W-bit ripple or prefix adder.

A subtracted operand costs no extra adder. It is bitwise inverted, and one constant operand is added to the tree. That constant equals the number of subtracted operands and supplies all of the missing "+1" terms at once. The compressors are scheduled by readiness depth. At each level, the vectors whose depth is at most the level number are grouped in list order, three at a time. Leftover vectors and vectors that are not yet ready wait for a later level.

The block is meant for accumulators, checksum and address arithmetic, and filter taps, where several terms with fixed signs meet in one cycle.

Top module: `csa_tree_sum`

## Requirements
- R1: `sum_o` equals the sum of all N resized operands, each added or subtracted according to its bit in `NEG_MASK`, taken modulo 2^W.
- R2: An operand whose bit in `SIGNED_MASK` is 1 and whose width `OP_W[i]` is below W is sign-extended. Bit `OP_W[i]-1` is copied into every higher position.
- R3: An operand whose bit in `SIGNED_MASK` is 0 and whose width is below W is zero-extended.
- R4: Bits of `opnds_i[i]` at positions `OP_W[i]` and above have no effect on `sum_o`.
- R5: A subtracted operand contributes its exact two's-complement negative. This also holds when every operand is subtracted.
- R6: Every 3:2 compressor preserves the arithmetic sum modulo 2^W. The carry vector is shifted up by one bit with a 0 in bit 0, and its top carry is dropped.
- R7: When N = 2 and no operand is subtracted, the block reduces to one W-bit adder whose carry-out is discarded.
- R8: When every operand is all zeros, `sum_o` is zero, for any masks.
- R9: All-ones operands and the most negative signed value (only bit `OP_W[i]-1` set) produce the modulo-2^W sum defined by R1 to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnds_i | input | N*W (N x W packed) | Operand i is `opnds_i[i]`; only its low `OP_W[i]` bits are meaningful |
| sum_o | output | W | Modulo-2^W signed/unsigned sum of all operands |

## Verification
The block has no registers, so every result is due in the same cycle as its stimulus, after combinational settling. The bench changes the operands 2 ns after a rising clock edge and samples `sum_o` 4 ns later, well before the next edge. Each check therefore sees only the settled response to one operand set. Expected values come from a bench function that sign- or zero-extends each operand and applies its plus or minus. A few corner results are also written out by hand.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int MAX_OPS = 32;
  localparam int IDX_W   = 8;
  localparam int MAX_FA  = MAX_OPS - 2;
  localparam int PLAN_W  = (3 * MAX_FA + 2) * IDX_W;

  function automatic int count_set(logic [MAX_OPS-1:0] v);
    int c = 0;
    for (int k = 0; k < MAX_OPS; k++) c += int'(v[k]);
    return c;
  endfunction

  // Elaboration-time Wallace schedule: triples per compressor, then final pair.
  // Vector ids: 0..m-1 are inputs, compressor f yields sum m+2f and carry m+2f+1.
  function automatic logic [PLAN_W-1:0] wallace_plan(int m);
    logic [PLAN_W-1:0] plan;
    int li [MAX_OPS]; int ld [MAX_OPS];
    int ri [MAX_OPS]; int rd [MAX_OPS];
    int wi [MAX_OPS]; int wd [MAX_OPS];
    int cnt, rc, wc, nc, nxt, fa, i, d;
    plan = '0;
    for (int k = 0; k < MAX_OPS; k++) begin
      li[k] = k; ld[k] = 0; ri[k] = 0; rd[k] = 0; wi[k] = 0; wd[k] = 0;
    end
    cnt = m; nxt = m; fa = 0;
    for (int lvl = 0; lvl < 4 * MAX_OPS; lvl++) begin
      if (cnt > 2) begin
        rc = 0; wc = 0;
        for (int k = 0; k < cnt; k++) begin
          if (ld[k] <= lvl) begin ri[rc] = li[k]; rd[rc] = ld[k]; rc++; end
          else              begin wi[wc] = li[k]; wd[wc] = ld[k]; wc++; end
        end
        if (rc >= 3) begin
          nc = 0; i = 0;
          while (i + 2 < rc) begin
            plan[(3*fa)*IDX_W   +: IDX_W] = IDX_W'(ri[i]);
            plan[(3*fa+1)*IDX_W +: IDX_W] = IDX_W'(ri[i+1]);
            plan[(3*fa+2)*IDX_W +: IDX_W] = IDX_W'(ri[i+2]);
            d = rd[i];
            if (rd[i+1] > d) d = rd[i+1];
            if (rd[i+2] > d) d = rd[i+2];
            li[nc] = nxt;     ld[nc] = d + 1;
            li[nc+1] = nxt+1; ld[nc+1] = d + 1;
            nc += 2; nxt += 2; fa++; i += 3;
          end
          for (; i < rc; i++) begin li[nc] = ri[i]; ld[nc] = rd[i]; nc++; end
          for (int k = 0; k < wc; k++) begin li[nc] = wi[k]; ld[nc] = wd[k]; nc++; end
          cnt = nc;
        end
      end
    end
    plan[(3*MAX_FA)*IDX_W   +: IDX_W] = IDX_W'(li[0]);
    plan[(3*MAX_FA+1)*IDX_W +: IDX_W] = IDX_W'(li[1]);
    return plan;
  endfunction

endpackage

// File: rtl/csa_operand_prep.sv
module csa_operand_prep #(
  parameter int   W      = 16,
  parameter int   OPW    = 16,
  parameter logic SIGNED = 1'b0,
  parameter logic NEG    = 1'b0
) (
  input  logic [W-1:0] op_i,
  output logic [W-1:0] ext_o
);
  localparam int EW = (OPW < 1) ? 1 : ((OPW > W) ? W : OPW);
  localparam logic [W-1:0] LOW_MASK = (EW == W) ? '1 : ((W'(1) << EW) - W'(1));

  logic         fill;
  logic [W-1:0] resized;

  assign fill    = SIGNED ? op_i[EW-1] : 1'b0;
  assign resized = (op_i & LOW_MASK) | (fill ? ~LOW_MASK : '0);

  generate
    if (NEG) begin : g_neg
      assign ext_o = ~resized;
    end else begin : g_pos
      assign ext_o = resized;
    end
  endgenerate

  always_comb begin
    if (NEG) begin
      // R5: inverted value plus one is the negative
      a_r5_negation_exact: assert (W'(ext_o + resized + W'(1)) == '0);
    end
  end
endmodule

// File: rtl/csa_fa3.sv
module csa_fa3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] maj;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign maj     = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign carry_o = {maj[W-2:0], 1'b0};

  always_comb begin
    a_r6_fa_conserves: assert (W'(a_i + b_i + c_i) == W'(sum_o + carry_o));
  end
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  assign s_o = x_i + y_i;
endmodule

// File: rtl/csa_tree_sum.sv
module csa_tree_sum
  import csa_pkg::*;
#(
  parameter int               N           = 6,
  parameter int               W           = 16,
  parameter logic [N-1:0][7:0] OP_W       = {8'd16, 8'd10, 8'd16, 8'd8, 8'd12, 8'd16},
  parameter logic [N-1:0]     SIGNED_MASK = 6'b011010,
  parameter logic [N-1:0]     NEG_MASK    = 6'b100110
) (
  input  logic [N-1:0][W-1:0] opnds_i,
  output logic [W-1:0]        sum_o
);
  localparam int NNEG  = count_set(MAX_OPS'(NEG_MASK));
  localparam int M     = N + ((NNEG > 0) ? 1 : 0);
  localparam int NFA   = M - 2;
  localparam int TOTAL = M + 2 * NFA;
  localparam logic [PLAN_W-1:0] PLAN = wallace_plan(M);
  localparam int FX = int'(PLAN[(3*MAX_FA)*IDX_W   +: IDX_W]);
  localparam int FY = int'(PLAN[(3*MAX_FA+1)*IDX_W +: IDX_W]);

  logic [W-1:0] vec [TOTAL];

  generate
    for (genvar i = 0; i < N; i++) begin : g_prep
      csa_operand_prep #(
        .W(W), .OPW(int'(OP_W[i])), .SIGNED(SIGNED_MASK[i]), .NEG(NEG_MASK[i])
      ) u_prep (
        .op_i (opnds_i[i]),
        .ext_o(vec[i])
      );
    end

    if (NNEG > 0) begin : g_corr
      assign vec[N] = W'(NNEG);
    end

    for (genvar k = 0; k < NFA; k++) begin : g_fa
      localparam int IA = int'(PLAN[(3*k)*IDX_W   +: IDX_W]);
      localparam int IB = int'(PLAN[(3*k+1)*IDX_W +: IDX_W]);
      localparam int IC = int'(PLAN[(3*k+2)*IDX_W +: IDX_W]);
      csa_fa3 #(.W(W)) u_fa (
        .a_i    (vec[IA]),
        .b_i    (vec[IB]),
        .c_i    (vec[IC]),
        .sum_o  (vec[M + 2*k]),
        .carry_o(vec[M + 2*k + 1])
      );
    end
  endgenerate

  csa_cpa #(.W(W)) u_cpa (
    .x_i(vec[FX]),
    .y_i(vec[FY]),
    .s_o(sum_o)
  );

  // Arithmetic model of R1 to R3, compared with the tree output.
  logic [W-1:0] model_sum;
  always_comb begin
    longint acc;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      longint v;
      int ew;
      ew = (int'(OP_W[i]) > W) ? W : ((int'(OP_W[i]) < 1) ? 1 : int'(OP_W[i]));
      v = longint'(opnds_i[i]) & ((longint'(1) << ew) - 1);
      if (SIGNED_MASK[i] && opnds_i[i][ew-1]) v = v - (longint'(1) << ew);
      acc = NEG_MASK[i] ? acc - v : acc + v;
    end
    model_sum = W'(acc);
    a_r1_matches_model: assert (sum_o == model_sum);
    if (opnds_i == '0) begin
      a_r8_zero_in_zero_out: assert (sum_o == '0);
    end
  end
endmodule

// File: tb/csa_tree_sum_test.sv
module csa_tree_sum_test;
  localparam int N = 6;
  localparam int W = 16;
  localparam int T_OPW [8] = '{16, 12, 8, 16, 10, 16, 0, 0};
  localparam logic [7:0] T_SG = 8'b00011010;
  localparam logic [7:0] T_NG = 8'b00100110;

  localparam logic [N-1:0][W-1:0] STIM [8] = '{
    {16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 16'h0006},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
    {16'h1234, 16'h0200, 16'h7FFF, 16'h0080, 16'h0800, 16'hFFFF},
    {16'hA5A5, 16'h5A5A, 16'h3C3C, 16'hC3C3, 16'h0F0F, 16'hF0F0},
    {16'h0000, 16'h01FF, 16'h8000, 16'h00FF, 16'h07FF, 16'h0001},
    {16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D, 16'h1357, 16'h2468},
    {16'h7FFF, 16'h03FF, 16'h0000, 16'h007F, 16'h0FFF, 16'h8000}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0][W-1:0] op_main = '0;
  logic [W-1:0]        sum_main;
  logic [1:0][7:0]     op_pair = '0;
  logic [7:0]          sum_pair;
  logic [3:0][11:0]    op_neg = '0;
  logic [11:0]         sum_neg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  csa_tree_sum #(
    .N(N), .W(W),
    .OP_W({8'd16, 8'd10, 8'd16, 8'd8, 8'd12, 8'd16}),
    .SIGNED_MASK(6'b011010), .NEG_MASK(6'b100110)
  ) uut (.opnds_i(op_main), .sum_o(sum_main));

  csa_tree_sum #(
    .N(2), .W(8), .OP_W({8'd8, 8'd8}), .SIGNED_MASK(2'b00), .NEG_MASK(2'b00)
  ) uut_pair (.opnds_i(op_pair), .sum_o(sum_pair));

  csa_tree_sum #(
    .N(4), .W(12), .OP_W({8'd12, 8'd12, 8'd12, 8'd12}),
    .SIGNED_MASK(4'b0101), .NEG_MASK(4'b1111)
  ) uut_allneg (.opnds_i(op_neg), .sum_o(sum_neg));

  function automatic logic [15:0] ref_sum(int n, int w, int opw [8], logic [7:0] sg,
                                          logic [7:0] ng, logic [15:0] ops [8]);
    longint acc = 0;
    for (int i = 0; i < n; i++) begin
      int ew;
      longint v;
      ew = (opw[i] > w) ? w : opw[i];
      v = longint'(ops[i]) & ((longint'(1) << ew) - 1);
      if (sg[i] && ((v >> (ew - 1)) & 1) == 1) v = v - (longint'(1) << ew);
      acc = ng[i] ? acc - v : acc + v;
    end
    return 16'(acc & ((longint'(1) << w) - 1));
  endfunction

  function automatic logic [15:0] ref_main(logic [N-1:0][W-1:0] v);
    logic [15:0] ops [8];
    for (int i = 0; i < 8; i++) ops[i] = (i < N) ? v[i] : 16'h0;
    return ref_sum(N, W, T_OPW, T_SG, T_NG, ops);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply_main(logic [N-1:0][W-1:0] v);
    @(posedge clk);
    #2 op_main = v;
    #4;
  endtask

  initial begin
    // R8: zero inputs stand in for the reset state of a stateless block
    #6;
    check("R8 zero main", sum_main, 16'h0000);
    check("R8 zero pair", {8'h00, sum_pair}, 16'h0000);
    check("R8 zero allneg", {4'h0, sum_neg}, 16'h0000);

    // R1/R9: table of stimulus, expected from bench model
    for (int t = 0; t < 8; t++) begin
      apply_main(STIM[t]);
      check("R1 table", sum_main, ref_main(STIM[t]));
    end

    // R6: random sums exercise every compressor
    for (int t = 0; t < 200; t++) begin
      logic [N-1:0][W-1:0] rv;
      for (int i = 0; i < N; i++) rv[i] = 16'($urandom);
      apply_main(rv);
      check("R6 random", sum_main, ref_main(rv));
    end

    // R2: op1 signed 12-bit subtracted, most negative -> +2048
    apply_main({16'h0, 16'h0, 16'h0, 16'h0, 16'h0800, 16'h0});
    check("R2 signed neg ext", sum_main, 16'h0800);
    // R2: op4 signed 10-bit added, 0x200 -> -512
    apply_main({16'h0, 16'h0200, 16'h0, 16'h0, 16'h0, 16'h0});
    check("R2 signed add ext", sum_main, 16'hFE00);
    // R4: upper bits above width 12 ignored
    apply_main({16'h0, 16'h0, 16'h0, 16'h0, 16'h7800, 16'h0});
    check("R4 upper ignored signed", sum_main, 16'h0800);
    // R3: op2 unsigned 8-bit subtracted, 0xFF -> -255
    apply_main({16'h0, 16'h0, 16'h0, 16'h00FF, 16'h0, 16'h0});
    check("R3 zero ext", sum_main, 16'hFF01);
    // R4: op2 upper bits ignored, 0xAB05 -> -5
    apply_main({16'h0, 16'h0, 16'h0, 16'hAB05, 16'h0, 16'h0});
    check("R4 upper ignored unsigned", sum_main, 16'hFFFB);
    // R1/R9: op0 all ones plus op3 one wraps to zero
    apply_main({16'h0, 16'h0, 16'h0001, 16'h0, 16'h0, 16'hFFFF});
    check("R9 wrap", sum_main, 16'h0000);
    // R5: op5 unsigned 16-bit subtracted alone
    apply_main({16'h0001, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0});
    check("R5 single subtract", sum_main, 16'hFFFF);

    // R7: two-operand degenerate adder
    @(posedge clk); #2 op_pair = {8'h01, 8'hFF}; #4;
    check("R7 pair wrap", {8'h00, sum_pair}, 16'h0000);
    @(posedge clk); #2 op_pair = {8'h5A, 8'h23}; #4;
    check("R7 pair add", {8'h00, sum_pair}, 16'h007D);

    // R5/R9: all operands subtracted
    @(posedge clk); #2 op_neg = {4{12'hFFF}}; #4;
    check("R5 allneg ones", {4'h0, sum_neg}, 16'h0004);
    @(posedge clk); #2 op_neg = {4{12'h800}}; #4;
    check("R9 allneg mostneg", {4'h0, sum_neg}, 16'h0000);
    @(posedge clk); #2 op_neg = {12'h003, 12'h005, 12'h007, 12'h00B}; #4;
    check("R5 allneg mixed", {4'h0, sum_neg}, 16'h0FE6);

    // R8: zero again after activity, main instance
    apply_main('0);
    check("R8 zero return", sum_main, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule